// File: doc/BRIEF.md
# Interrupt and Low-Power Sequencer

This block is the control sequencer that sits beside the instruction decoder of an 8-bit accumulator CPU. It decides when execution halts on a wait or stop opcode and when it resumes. It also steps the processor through interrupt entry. That entry runs as a fixed order of bus cycles: three stack pushes (return address high byte, return address low byte, status), then a low and a high vector read. The decimal-mode clear is issued in the first vector cycle, so it always follows the status push.

The decoder reports stop, wait and break opcodes as one-cycle strobes at the instruction boundary. The interrupt inputs are an edge-triggered non-maskable request and a level-sensitive maskable request, which is gated by the I flag. A ready input stalls every step. The sequencer drives the address of each push and vector cycle itself, so the rest of the core only has to supply the stack pointer and carry out the strobes.

Top module: `irq_halt_seq`

## Requirements
- R1: While reset is low, and in the first ready cycle after it rises, the state is 4 with address FFFC, the vector-low strobe and the decimal clear both high, and no push. The next cycle is state 5 at FFFD, then state 0 (run).
- R2: A taken interrupt or break moves state 0 to 1, 2, 3, 4, 5 and back to 0, one step per ready cycle. The push strobe is one-hot: bit 0 for the return high byte in state 1, bit 1 for the low byte in state 2, bit 2 for the status in state 3.
- R3: The push addresses are {01, sp}, then {01, sp-1}, then {01, sp-2}, where sp is the stack pointer input sampled as entry begins.
- R4: The decimal clear is asserted only in state 4, so it never comes before the status push of the same entry.
- R5: The vector-pull flag is high exactly in states 4 and 5. The vector reads go to the low address and then the address plus one: FFFA for a non-maskable request, FFFE for a maskable request or a break.
- R6: A rising edge of the non-maskable request starts entry on the next clock edge, and it wins over a maskable request that arrives at the same time. Holding the request high does not start a second entry.
- R7: A maskable request while the I flag is 1 leaves the run state untouched, with no push.
- R8: A wait strobe moves to state 6 with the halted output high. An unmasked maskable request or a non-maskable edge there starts entry (state 1) at the next edge.
- R9: In state 6, a maskable request with the I flag set returns to state 0 at the next edge, with no push and no vector read.
- R10: A stop strobe moves to state 7 with the halted output high. Interrupt requests leave it there, and only reset ends it.
- R11: When a break strobe coincides with a hardware interrupt, the hardware entry runs first. The break entry (vector FFFE) starts at the edge after the first run cycle that follows.
- R12: In states 6 and 7, every strobe and the vector-pull flag are low and the address output does not change.
- R13: With ready low, the state holds and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Maskable interrupt request, level |
| nmi_req | input | 1 | Non-maskable request, rising edge |
| i_flag | input | 1 | Interrupt-disable flag from status |
| op_stop | input | 1 | Stop opcode decoded at boundary |
| op_wait | input | 1 | Wait opcode decoded at boundary |
| op_brk | input | 1 | Break opcode decoded at boundary |
| rdy | input | 1 | Ready; low stalls the sequencer |
| sp_i | input | SP_W | Current stack pointer |
| state_o | output | 3 | State code (0 run, 1-3 push, 4-5 vector, 6 wait, 7 stop) |
| push_o | output | 3 | One-hot push strobe |
| vec_lo_o | output | 1 | Vector low-byte read strobe |
| vec_hi_o | output | 1 | Vector high-byte read strobe |
| vpull_o | output | 1 | Vector-pull bus flag |
| dclr_o | output | 1 | Clear the decimal flag |
| halted_o | output | 1 | In wait or stop |
| addr_o | output | ADDR_W | Address for push and vector cycles |

## Verification
The state code and the address are registered, so a strobe sampled at a rising edge shows its effect right after that edge. Examples are entry state 1 after an interrupt, state 6 after a wait strobe, and state 0 after a masked wake. Each further entry step appears one ready edge later. The strobes are combinational in the state and ready, so they are valid in the same window. The bench changes inputs and samples outputs one time unit after each rising edge. It counts edges to each expected state: six edges for a whole entry, and one extra run cycle before a deferred break starts.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_PSH_H = 3'd1,
      ST_PSH_L = 3'd2,
      ST_PSH_P = 3'd3,
      ST_VEC_L = 3'd4,
      ST_VEC_H = 3'd5,
      ST_WAIT  = 3'd6,
      ST_STOP  = 3'd7
   } seq_state_t;

   typedef struct packed {
      logic stop;
      logic wt;
      logic brk;
   } op_set_t;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_req,
   input  logic take,
   output logic nmi_now
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_q, pend_q, rise;
         assign rise    = nmi_req & ~prev_q;
         assign nmi_now = pend_q | rise;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= nmi_req;
               pend_q <= (pend_q | rise) & ~take;
            end
         end
      end else begin : g_level
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ take;
         assign nmi_now   = nmi_req;
      end
   endgenerate
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE
) (
   input  logic              nmi_now,
   input  logic              irq_req,
   input  logic              i_flag,
   output logic              hw_take,
   output logic              hw_is_nmi,
   output logic [ADDR_W-1:0] hw_vec,
   output logic              masked_wake
);
   always_comb begin
      hw_is_nmi   = nmi_now;
      hw_take     = nmi_now | (irq_req & ~i_flag);
      hw_vec      = nmi_now ? VEC_NMI : VEC_IRQ;
      masked_wake = irq_req & i_flag & ~nmi_now;
   end
endmodule

// File: rtl/irq_step_fsm.sv
module irq_step_fsm
   import irq_halt_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned SP_W   = 8,
   parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 'h01,
   parameter logic [ADDR_W-1:0] VEC_RST = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rdy,
   input  logic              op_stop,
   input  logic              op_wait,
   input  logic              op_brk,
   input  logic [SP_W-1:0]   sp_i,
   input  logic              hw_take,
   input  logic              hw_is_nmi,
   input  logic [ADDR_W-1:0] hw_vec,
   input  logic              masked_wake,
   output seq_state_t        state,
   output logic [ADDR_W-1:0] addr_q,
   output logic              nmi_take
);
   localparam logic [SP_W-1:0]   SP_ONE = SP_W'(1);
   localparam logic [SP_W-1:0]   SP_TWO = SP_W'(2);
   localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);

   seq_state_t        nxt;
   op_set_t           defer_q, defer_n, strobes, op_now;
   logic [SP_W-1:0]   sp_q;
   logic [ADDR_W-1:0] vbase_q, nvec, addr_n;
   logic              take_n;

   assign strobes = '{stop: op_stop, wt: op_wait, brk: op_brk};
   assign op_now  = (defer_q != '0) ? defer_q : strobes;

   always_comb begin
      nxt     = state;
      nvec    = vbase_q;
      defer_n = defer_q;
      take_n  = 1'b0;
      unique case (state)
         ST_RUN: begin
            if (hw_take) begin
               nxt    = ST_PSH_H;
               nvec   = hw_vec;
               take_n = hw_is_nmi;
               if (defer_q == '0) defer_n = strobes;
            end else begin
               defer_n = '0;
               if (op_now.stop)     nxt = ST_STOP;
               else if (op_now.wt)  nxt = ST_WAIT;
               else if (op_now.brk) begin
                  nxt  = ST_PSH_H;
                  nvec = VEC_IRQ;
               end
            end
         end
         ST_PSH_H: nxt = ST_PSH_L;
         ST_PSH_L: nxt = ST_PSH_P;
         ST_PSH_P: nxt = ST_VEC_L;
         ST_VEC_L: nxt = ST_VEC_H;
         ST_VEC_H: nxt = ST_RUN;
         ST_WAIT: begin
            if (hw_take) begin
               nxt    = ST_PSH_H;
               nvec   = hw_vec;
               take_n = hw_is_nmi;
            end else if (masked_wake) begin
               nxt = ST_RUN;
            end
         end
         default: nxt = ST_STOP;
      endcase
      if (!rdy) begin
         nxt     = state;
         nvec    = vbase_q;
         defer_n = defer_q;
         take_n  = 1'b0;
      end
   end

   always_comb begin
      addr_n = addr_q;
      if (nxt != state) begin
         unique case (nxt)
            ST_PSH_H: addr_n = {STACK_PAGE, sp_i};
            ST_PSH_L: addr_n = {STACK_PAGE, sp_q - SP_ONE};
            ST_PSH_P: addr_n = {STACK_PAGE, sp_q - SP_TWO};
            ST_VEC_L: addr_n = nvec;
            ST_VEC_H: addr_n = nvec + A_ONE;
            default:  addr_n = addr_q;
         endcase
      end
   end

   assign nmi_take = take_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_VEC_L;
         vbase_q <= VEC_RST;
         addr_q  <= VEC_RST;
         defer_q <= '0;
         sp_q    <= '0;
      end else begin
         state   <= nxt;
         vbase_q <= nvec;
         addr_q  <= addr_n;
         defer_q <= defer_n;
         if (nxt == ST_PSH_H && state != ST_PSH_H) sp_q <= sp_i;
      end
   end
endmodule

// File: rtl/irq_halt_seq.sv
module irq_halt_seq
   import irq_halt_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned SP_W   = 8,
   parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 'h01,
   parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_RST = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE,
   parameter bit NMI_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              nmi_req,
   input  logic              i_flag,
   input  logic              op_stop,
   input  logic              op_wait,
   input  logic              op_brk,
   input  logic              rdy,
   input  logic [SP_W-1:0]   sp_i,
   output logic [2:0]        state_o,
   output logic [2:0]        push_o,
   output logic              vec_lo_o,
   output logic              vec_hi_o,
   output logic              vpull_o,
   output logic              dclr_o,
   output logic              halted_o,
   output logic [ADDR_W-1:0] addr_o
);
   generate
      if (ADDR_W <= SP_W) begin : g_bad_width
         $error("irq_halt_seq: ADDR_W must exceed SP_W");
      end
      if (VEC_NMI[0] || VEC_RST[0] || VEC_IRQ[0]) begin : g_bad_vec
         $error("irq_halt_seq: vectors must be even");
      end
   endgenerate

   seq_state_t        state;
   logic              nmi_now, nmi_take, hw_take, hw_is_nmi, masked_wake;
   logic [ADDR_W-1:0] hw_vec;

   irq_nmi_latch #(.EDGE_MODE(NMI_EDGE)) u_nmi (
      .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req),
      .take(nmi_take), .nmi_now(nmi_now)
   );

   irq_arbiter #(.ADDR_W(ADDR_W), .VEC_NMI(VEC_NMI), .VEC_IRQ(VEC_IRQ)) u_arb (
      .nmi_now(nmi_now), .irq_req(irq_req), .i_flag(i_flag),
      .hw_take(hw_take), .hw_is_nmi(hw_is_nmi), .hw_vec(hw_vec),
      .masked_wake(masked_wake)
   );

   irq_step_fsm #(
      .ADDR_W(ADDR_W), .SP_W(SP_W), .STACK_PAGE(STACK_PAGE),
      .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .rdy(rdy),
      .op_stop(op_stop), .op_wait(op_wait), .op_brk(op_brk), .sp_i(sp_i),
      .hw_take(hw_take), .hw_is_nmi(hw_is_nmi), .hw_vec(hw_vec),
      .masked_wake(masked_wake),
      .state(state), .addr_q(addr_o), .nmi_take(nmi_take)
   );

   always_comb begin
      state_o  = state;
      push_o   = {state == ST_PSH_P, state == ST_PSH_L, state == ST_PSH_H} & {3{rdy}};
      vec_lo_o = (state == ST_VEC_L) & rdy;
      vec_hi_o = (state == ST_VEC_H) & rdy;
      vpull_o  = (state == ST_VEC_L) | (state == ST_VEC_H);
      dclr_o   = (state == ST_VEC_L) & rdy;
      halted_o = (state == ST_WAIT) | (state == ST_STOP);
   end
endmodule

// File: rtl/irq_halt_seq_chk.sv
module irq_halt_seq_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned SP_W   = 8,
   parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 'h01
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rdy,
   input logic              irq_req,
   input logic              i_flag,
   input logic [2:0]        state_o,
   input logic [2:0]        push_o,
   input logic              vec_lo_o,
   input logic              vec_hi_o,
   input logic              vpull_o,
   input logic              dclr_o,
   input logic              halted_o,
   input logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

   assert_push_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(push_o));
   assert_entry_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd1 && rdy) |=> state_o == 3'd2);
   assert_status_to_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd3 && rdy) |=> state_o == 3'd4);
   assert_stack_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o != 3'b000) |-> addr_o[ADDR_W-1:SP_W] == STACK_PAGE);
   assert_stack_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o[1] && $past(state_o) == 3'd1) |-> addr_o == $past(addr_o) - A_ONE);
   assert_dclr_after_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dclr_o |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd4));
   assert_vec_hi_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_hi_o |-> ($past(state_o) == 3'd4 || $past(state_o) == 3'd5));
   assert_vec_lo_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_lo_o |-> (addr_o[0] == 1'b0 && vpull_o));
   assert_wait_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd6 && rdy && irq_req && !i_flag) |=> state_o == 3'd1);
   assert_stop_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd7) |=> state_o == 3'd7);
   assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> (push_o == 3'b000 && !vec_lo_o && !vec_hi_o && !vpull_o && !dclr_o));
   assert_halt_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && $past(halted_o)) |-> $stable(addr_o));
   assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |=> $stable(state_o));
   assert_stall_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |-> (push_o == 3'b000 && !vec_lo_o && !vec_hi_o));
endmodule

bind irq_halt_seq irq_halt_seq_chk #(
   .ADDR_W(ADDR_W), .SP_W(SP_W), .STACK_PAGE(STACK_PAGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rdy(rdy), .irq_req(irq_req), .i_flag(i_flag),
   .state_o(state_o), .push_o(push_o), .vec_lo_o(vec_lo_o), .vec_hi_o(vec_hi_o),
   .vpull_o(vpull_o), .dclr_o(dclr_o), .halted_o(halted_o), .addr_o(addr_o)
);

// File: tb/irq_halt_seq_tb.sv
module irq_halt_seq_tb;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_req = 1'b0, nmi_req = 1'b0, i_flag = 1'b0;
   logic op_stop = 1'b0, op_wait = 1'b0, op_brk = 1'b0, rdy = 1'b1;
   logic [7:0]  sp_i = 8'hF0;
   logic [2:0]  state_o, push_o;
   logic        vec_lo_o, vec_hi_o, vpull_o, dclr_o, halted_o;
   logic [15:0] addr_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irq_halt_seq u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
      .i_flag(i_flag), .op_stop(op_stop), .op_wait(op_wait), .op_brk(op_brk),
      .rdy(rdy), .sp_i(sp_i), .state_o(state_o), .push_o(push_o),
      .vec_lo_o(vec_lo_o), .vec_hi_o(vec_hi_o), .vpull_o(vpull_o),
      .dclr_o(dclr_o), .halted_o(halted_o), .addr_o(addr_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic expect_entry(string req, logic [7:0] sp, logic [15:0] vec);
      logic [7:0] s1, s2;
      s1 = sp - 8'd1;
      s2 = sp - 8'd2;
      check(req, "state push hi (R2)", {29'd0, state_o}, 32'd1);
      check(req, "push hi strobe (R2)", {29'd0, push_o}, 32'd1);
      check(req, "addr push hi (R3)", {16'd0, addr_o}, {16'd0, 8'h01, sp});
      tick();
      check(req, "state push lo (R2)", {29'd0, state_o}, 32'd2);
      check(req, "push lo strobe (R2)", {29'd0, push_o}, 32'd2);
      check(req, "addr push lo (R3)", {16'd0, addr_o}, {16'd0, 8'h01, s1});
      tick();
      check(req, "state push status (R2)", {29'd0, state_o}, 32'd3);
      check(req, "push status strobe (R2)", {29'd0, push_o}, 32'd4);
      check(req, "addr push status (R3)", {16'd0, addr_o}, {16'd0, 8'h01, s2});
      check(req, "no dclr before status done (R4)", {31'd0, dclr_o}, 32'd0);
      check(req, "no vpull in push (R5)", {31'd0, vpull_o}, 32'd0);
      tick();
      check(req, "state vec lo (R5)", {29'd0, state_o}, 32'd4);
      check(req, "vec lo strobe (R5)", {31'd0, vec_lo_o}, 32'd1);
      check(req, "vpull lo (R5)", {31'd0, vpull_o}, 32'd1);
      check(req, "dclr after status (R4)", {31'd0, dclr_o}, 32'd1);
      check(req, "vec lo addr (R5)", {16'd0, addr_o}, {16'd0, vec});
      tick();
      check(req, "state vec hi (R5)", {29'd0, state_o}, 32'd5);
      check(req, "vec hi strobe (R5)", {31'd0, vec_hi_o}, 32'd1);
      check(req, "dclr single cycle (R4)", {31'd0, dclr_o}, 32'd0);
      check(req, "vec hi addr (R5)", {16'd0, addr_o}, {16'd0, vec + 16'd1});
      tick();
      check(req, "back to run (R2)", {29'd0, state_o}, 32'd0);
      check(req, "vpull off (R5)", {31'd0, vpull_o}, 32'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; rdy = 1'b1;
      irq_req = 1'b0; nmi_req = 1'b0; op_stop = 1'b0; op_wait = 1'b0; op_brk = 1'b0;
      tick(); tick();
      check("R1", "reset state", {29'd0, state_o}, 32'd4);
      check("R1", "reset addr", {16'd0, addr_o}, 32'hFFFC);
      check("R1", "reset no push", {29'd0, push_o}, 32'd0);
      rst_n = 1'b1;
      #1;
      check("R1", "first cycle vec lo", {31'd0, vec_lo_o}, 32'd1);
      check("R1", "reset dclr", {31'd0, dclr_o}, 32'd1);
      tick();
      check("R1", "reset vec hi state", {29'd0, state_o}, 32'd5);
      check("R1", "reset vec hi addr", {16'd0, addr_o}, 32'hFFFD);
      tick();
      check("R1", "run after reset", {29'd0, state_o}, 32'd0);
   endtask

   task automatic t_irq_entry();
      sp_i = 8'hF0; i_flag = 1'b0; irq_req = 1'b1;
      tick();
      irq_req = 1'b0;
      expect_entry("R2", 8'hF0, 16'hFFFE);
   endtask

   task automatic t_nmi_priority();
      sp_i = 8'h80; irq_req = 1'b1; nmi_req = 1'b1; i_flag = 1'b0;
      tick();
      irq_req = 1'b0;
      expect_entry("R6", 8'h80, 16'hFFFA);
      for (int k = 0; k < 3; k++) begin
         tick();
         check("R6", "held nmi no retrigger", {29'd0, state_o}, 32'd0);
      end
      nmi_req = 1'b0;
      tick();
   endtask

   task automatic t_masked_run();
      irq_req = 1'b1; i_flag = 1'b1;
      for (int k = 0; k < 4; k++) begin
         tick();
         check("R7", "masked irq stays run", {29'd0, state_o}, 32'd0);
         check("R7", "masked irq no push", {29'd0, push_o}, 32'd0);
      end
      irq_req = 1'b0; i_flag = 1'b0;
   endtask

   task automatic t_wait_irq();
      logic [15:0] held;
      op_wait = 1'b1;
      tick();
      op_wait = 1'b0;
      check("R8", "wait state", {29'd0, state_o}, 32'd6);
      check("R8", "wait halted", {31'd0, halted_o}, 32'd1);
      held = addr_o;
      sp_i = 8'h37;
      for (int k = 0; k < 3; k++) begin
         tick();
         check("R12", "wait strobes quiet", {26'd0, push_o, vec_lo_o, vec_hi_o, vpull_o},
               32'd0);
         check("R12", "wait addr frozen", {16'd0, addr_o}, {16'd0, held});
      end
      irq_req = 1'b1; i_flag = 1'b0;
      tick();
      irq_req = 1'b0;
      expect_entry("R8", 8'h37, 16'hFFFE);
   endtask

   task automatic t_wait_nmi();
      sp_i = 8'hF0;
      op_wait = 1'b1;
      tick();
      op_wait = 1'b0;
      tick();
      check("R8", "still waiting", {29'd0, state_o}, 32'd6);
      nmi_req = 1'b1;
      tick();
      expect_entry("R8", 8'hF0, 16'hFFFA);
      nmi_req = 1'b0;
      tick();
   endtask

   task automatic t_wait_masked();
      op_wait = 1'b1;
      tick();
      op_wait = 1'b0;
      check("R9", "enter wait", {29'd0, state_o}, 32'd6);
      irq_req = 1'b1; i_flag = 1'b1;
      tick();
      irq_req = 1'b0;
      check("R9", "masked wake to run", {29'd0, state_o}, 32'd0);
      check("R9", "masked wake no push", {29'd0, push_o}, 32'd0);
      check("R9", "masked wake not halted", {31'd0, halted_o}, 32'd0);
      tick();
      check("R9", "no entry follows", {29'd0, state_o}, 32'd0);
      check("R9", "no vector read", {31'd0, vpull_o}, 32'd0);
      i_flag = 1'b0;
   endtask

   task automatic t_stop();
      logic [15:0] held;
      op_stop = 1'b1;
      tick();
      op_stop = 1'b0;
      check("R10", "stop state", {29'd0, state_o}, 32'd7);
      held = addr_o;
      irq_req = 1'b1; nmi_req = 1'b1; i_flag = 1'b0;
      for (int k = 0; k < 4; k++) begin
         tick();
         check("R10", "stop ignores interrupts", {29'd0, state_o}, 32'd7);
         check("R10", "stop halted", {31'd0, halted_o}, 32'd1);
         check("R12", "stop addr frozen", {16'd0, addr_o}, {16'd0, held});
         check("R12", "stop strobes quiet", {29'd0, push_o}, 32'd0);
      end
      t_reset();
   endtask

   task automatic t_brk();
      sp_i = 8'h50;
      op_brk = 1'b1;
      tick();
      op_brk = 1'b0;
      expect_entry("R11", 8'h50, 16'hFFFE);
   endtask

   task automatic t_brk_coincide();
      sp_i = 8'hF0;
      op_brk = 1'b1; nmi_req = 1'b1;
      tick();
      op_brk = 1'b0; nmi_req = 1'b0;
      expect_entry("R11", 8'hF0, 16'hFFFA);
      tick();
      expect_entry("R11", 8'hF0, 16'hFFFE);
   endtask

   task automatic t_ready();
      sp_i = 8'hF0; irq_req = 1'b1; i_flag = 1'b0;
      tick();
      irq_req = 1'b0;
      rdy = 1'b0;
      #1;
      check("R13", "stall push quiet", {29'd0, push_o}, 32'd0);
      for (int k = 0; k < 2; k++) begin
         tick();
         check("R13", "stall holds state", {29'd0, state_o}, 32'd1);
         check("R13", "stall holds addr", {16'd0, addr_o}, 32'h01F0);
      end
      rdy = 1'b1;
      #1;
      check("R13", "resume push hi", {29'd0, push_o}, 32'd1);
      tick();
      check("R13", "resume advances", {29'd0, state_o}, 32'd2);
      tick(); tick(); tick(); tick();
      check("R13", "resume completes", {29'd0, state_o}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not finish actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_irq_entry();
      t_nmi_priority();
      t_masked_run();
      t_wait_irq();
      t_wait_nmi();
      t_wait_masked();
      t_brk();
      t_brk_coincide();
      t_ready();
      t_stop();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule